// File: doc/BRIEF.md
# Stream SIMD Integer ALU

This block runs integer stream instructions on a small bank of local vector registers. Each register holds eight 64-bit elements. An instruction has a 3-bit operation code and a 24-bit control word. The control word names a destination register, two source registers and three mode flags, and carries a 15-bit immediate. The block reads both source registers in full in the cycle the instruction is accepted. It then steps through the elements and writes the results back through a write port with one lane per arithmetic unit.

The block has three modes. In element-wise mode, each output element is `op(src1[e], src2[e])`, or `op(src1[e], imm)` when the immediate flag is set. Two units work in parallel and retire the elements in ascending pairs. In split mode, every 64-bit element is handled as two independent 32-bit lanes. In reduction mode, the eight elements of the first source are folded into one value, which is written to a single element of the destination. That element is chosen by the top three bits of the immediate. The walk around the ring of elements starts at that same element. Floating point and multiplication are not handled here.

Top module: `stsimd_int_alu`

## Requirements
- R1: After reset, `iss_ready` is 1 and `wr_en` is all zero, and no write is made while the block is idle.
- R2: The control word is decoded as follows: bits [23:22] are the destination, [21:20] source 1, [19:18] source 2, [17] split, [16] use-immediate, [15] reduction, and [14:0] the immediate. `rd_reg_a` and `rd_reg_b` follow bits [21:20] and [19:18] combinationally. Every write of an instruction goes to the destination register on a stable `wr_reg`.
- R3: Operation codes 0, 1, 4, 5 and 6 give ADD, SUB, AND, OR and XOR. ADD and SUB wrap modulo the lane width.
- R4: Code 2 (COMP) writes all ones to a lane when source 1 is less than the second operand as signed values, and zero otherwise.
- R5: Code 3 (SHIFT) shifts source 1 left logically. The amount is the low 6 bits of the second operand, or the low 5 bits in split mode.
- R6: With use-immediate set, the second operand of every element is the immediate. It is sign-extended to 64 bits, or to 32 bits and placed in both halves in split mode.
- R7: With split set, each 64-bit element is computed as two 32-bit lanes. No carry, sign or shift crosses from one lane to the other.
- R8: In element-wise mode, elements 2s and 2s+1 are written on ports 0 and 1 in the cycle after the (s+1)-th clock edge that follows the accepting edge. `iss_ready` is 0 from the accepting edge until the last pair is written.
- R9: In reduction mode, with h = imm[14:12], the accumulator starts as src1[h]. It then takes `acc = op(acc, src1[(h+j) mod 8])` for j = 1 to 7. The result is written once on port 0 to element h, after the seventh edge following acceptance. The other destination elements are left unchanged.
- R10: Operation code 7 is accepted, occupies the block for its normal duration, and makes no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | An instruction is offered |
| iss_ready | output | 1 | Block is idle and accepts an instruction |
| iss_op | input | 3 | Operation code |
| iss_ctrl | input | 24 | Control word (register fields, flags, immediate) |
| rd_reg_a | output | 2 | Local register read for source 1 |
| rd_reg_b | output | 2 | Local register read for source 2 |
| rd_data_a | input | 512 | All elements of the source 1 register, element 0 in the low bits |
| rd_data_b | input | 512 | All elements of the source 2 register, element 0 in the low bits |
| wr_reg | output | 2 | Destination register of the writes |
| wr_en | output | 2 | Per-unit write enable |
| wr_idx | output | 6 | Per-unit element index, 3 bits each |
| wr_data | output | 128 | Per-unit element data, 64 bits each |

## Verification
The bench builds the block with its default parameters: 64-bit elements, eight elements per register and two units. At this size every combination of the eight operation codes with the split, immediate and reduction flags can be issued several times. Each time, the reduction start element and the source/destination aliasing change. Fixed corner words (sign boundaries, all ones, and words whose low lane overflows into the high lane) are mixed into the operand registers. This exposes carry or sign leakage across split lanes and signed-compare mistakes. Write timing is measured against the accepting edge, which checks the pair order and the reduction latency exactly.

// File: rtl/stsimd_pkg.sv
package stsimd_pkg;

   localparam int CTRL_W = 24;
   localparam int IMM_W  = 15;
   localparam int RSEL_W = 2;

   typedef enum logic [2:0] {
      OP_ADD  = 3'd0,
      OP_SUB  = 3'd1,
      OP_CMP  = 3'd2,
      OP_SHL  = 3'd3,
      OP_AND  = 3'd4,
      OP_OR   = 3'd5,
      OP_XOR  = 3'd6,
      OP_NONE = 3'd7
   } alu_op_e;

   typedef struct packed {
      logic [RSEL_W-1:0] dst;
      logic [RSEL_W-1:0] sa;
      logic [RSEL_W-1:0] sb;
      logic              split;
      logic              use_imm;
      logic              reduce;
      logic [IMM_W-1:0]  imm;
   } ctrl_t;

endpackage

// File: rtl/stsimd_slice.sv
module stsimd_slice
   import stsimd_pkg::*;
#(
   parameter int W = 32
)(
   input  alu_op_e        op,
   input  logic [W-1:0]   a,
   input  logic [W-1:0]   b,
   output logic [W-1:0]   y
);
   localparam int SH_W = $clog2(W);

   always_comb begin
      case (op)
         OP_ADD:  y = a + b;
         OP_SUB:  y = a - b;
         OP_CMP:  y = ($signed(a) < $signed(b)) ? {W{1'b1}} : {W{1'b0}};
         OP_SHL:  y = a << b[SH_W-1:0];
         OP_AND:  y = a & b;
         OP_OR:   y = a | b;
         OP_XOR:  y = a ^ b;
         default: y = '0;
      endcase
   end
endmodule

// File: rtl/stsimd_unit.sv
module stsimd_unit
   import stsimd_pkg::*;
#(
   parameter int W         = 64,
   parameter bit HAS_SPLIT = 1'b1
)(
   input  alu_op_e      op,
   input  logic         split,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] y
);
   localparam int HW = W / 2;

   logic [W-1:0] y_full;

   stsimd_slice #(.W(W)) u_full (.op(op), .a(a), .b(b), .y(y_full));

   generate
      if (HAS_SPLIT) begin : g_split
         logic [HW-1:0] y_lo;
         logic [HW-1:0] y_hi;
         stsimd_slice #(.W(HW)) u_lo (.op(op), .a(a[HW-1:0]), .b(b[HW-1:0]), .y(y_lo));
         stsimd_slice #(.W(HW)) u_hi (.op(op), .a(a[W-1:HW]), .b(b[W-1:HW]), .y(y_hi));
         assign y = split ? {y_hi, y_lo} : y_full;
      end else begin : g_whole
         logic unused_split;
         assign unused_split = split;
         assign y = y_full;
      end
   endgenerate
endmodule

// File: rtl/stsimd_decode.sv
module stsimd_decode
   import stsimd_pkg::*;
#(
   parameter int ELEM_W = 64,
   parameter int N_ELEM = 8,
   localparam int IDX_W = $clog2(N_ELEM),
   localparam int HW    = ELEM_W / 2
)(
   input  logic [CTRL_W-1:0] ctrl,
   output logic [RSEL_W-1:0] dst,
   output logic [RSEL_W-1:0] sa,
   output logic [RSEL_W-1:0] sb,
   output logic              split,
   output logic              use_imm,
   output logic              reduce,
   output logic [IDX_W-1:0]  home,
   output logic [ELEM_W-1:0] imm_full,
   output logic [ELEM_W-1:0] imm_split
);
   ctrl_t f;
   logic [HW-1:0] imm_half;

   assign f        = ctrl_t'(ctrl);
   assign dst      = f.dst;
   assign sa       = f.sa;
   assign sb       = f.sb;
   assign split    = f.split;
   assign use_imm  = f.use_imm;
   assign reduce   = f.reduce;
   assign home     = f.imm[IMM_W-1 -: IDX_W];
   assign imm_full = {{(ELEM_W-IMM_W){f.imm[IMM_W-1]}}, f.imm};
   assign imm_half = {{(HW-IMM_W){f.imm[IMM_W-1]}}, f.imm};
   assign imm_split = {imm_half, imm_half};
endmodule

// File: rtl/stsimd_int_alu.sv
module stsimd_int_alu
   import stsimd_pkg::*;
#(
   parameter int ELEM_W   = 64,
   parameter int N_ELEM   = 8,
   parameter int N_UNITS  = 2,
   parameter bit SPLIT_EN = 1'b1,
   localparam int IDX_W   = $clog2(N_ELEM)
)(
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       iss_valid,
   output logic                       iss_ready,
   input  logic [2:0]                 iss_op,
   input  logic [CTRL_W-1:0]          iss_ctrl,
   output logic [RSEL_W-1:0]          rd_reg_a,
   output logic [RSEL_W-1:0]          rd_reg_b,
   input  logic [N_ELEM*ELEM_W-1:0]   rd_data_a,
   input  logic [N_ELEM*ELEM_W-1:0]   rd_data_b,
   output logic [RSEL_W-1:0]          wr_reg,
   output logic [N_UNITS-1:0]         wr_en,
   output logic [N_UNITS*IDX_W-1:0]   wr_idx,
   output logic [N_UNITS*ELEM_W-1:0]  wr_data
);
   localparam int STEPS = N_ELEM / N_UNITS;
   localparam int CNT_W = (IDX_W < 1) ? 1 : IDX_W;
   localparam logic [CNT_W-1:0] LAST_PAIR = CNT_W'(STEPS - 1);
   localparam logic [CNT_W-1:0] LAST_FOLD = CNT_W'(N_ELEM - 2);

   initial begin : p_param_chk
      if (ELEM_W < 2 * IMM_W + 2 || (ELEM_W % 2) != 0)
         $error("stsimd_int_alu: ELEM_W must be even and at least 32");
      if (N_ELEM < 4 || (1 << IDX_W) != N_ELEM)
         $error("stsimd_int_alu: N_ELEM must be a power of two, 4 or more");
      if (N_UNITS < 1 || (N_ELEM % N_UNITS) != 0)
         $error("stsimd_int_alu: N_UNITS must divide N_ELEM");
   end

   // decode of the offered instruction
   logic [RSEL_W-1:0] d_dst, d_sa, d_sb;
   logic              d_split, d_use_imm, d_reduce;
   logic [IDX_W-1:0]  d_home;
   logic [ELEM_W-1:0] d_imm_full, d_imm_split, d_imm_sel;

   stsimd_decode #(.ELEM_W(ELEM_W), .N_ELEM(N_ELEM)) u_dec (
      .ctrl(iss_ctrl), .dst(d_dst), .sa(d_sa), .sb(d_sb),
      .split(d_split), .use_imm(d_use_imm), .reduce(d_reduce),
      .home(d_home), .imm_full(d_imm_full), .imm_split(d_imm_split)
   );

   assign rd_reg_a  = d_sa;
   assign rd_reg_b  = d_sb;
   assign d_imm_sel = (SPLIT_EN && d_split) ? d_imm_split : d_imm_full;

   // sequencer state
   logic              busy_q, red_q, split_q, use_imm_q;
   logic [CNT_W-1:0]  cnt_q;
   alu_op_e           op_q;
   logic [ELEM_W-1:0] imm_q, acc_q;
   logic [IDX_W-1:0]  ptr_q, home_q;
   logic [ELEM_W-1:0] s1_q [N_ELEM];
   logic [ELEM_W-1:0] s2_q [N_ELEM];
   logic              accept, op_ok;

   assign iss_ready = !busy_q;
   assign accept    = iss_valid && !busy_q;
   assign op_ok     = (op_q != OP_NONE);

   // parallel units
   logic [ELEM_W-1:0] unit_y   [N_UNITS];
   logic [IDX_W-1:0]  elem_idx [N_UNITS];

   generate
      for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
         logic [ELEM_W-1:0] opa, opb;
         assign elem_idx[u] = IDX_W'(int'(cnt_q) * N_UNITS + u);
         if (u == 0) begin : g_lead
            assign opa = red_q ? acc_q : s1_q[elem_idx[u]];
         end else begin : g_rest
            assign opa = red_q ? '0 : s1_q[elem_idx[u]];
         end
         assign opb = red_q ? s1_q[ptr_q] : (use_imm_q ? imm_q : s2_q[elem_idx[u]]);
         stsimd_unit #(.W(ELEM_W), .HAS_SPLIT(SPLIT_EN)) u_alu (
            .op(op_q), .split(split_q), .a(opa), .b(opb), .y(unit_y[u])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         red_q     <= 1'b0;
         split_q   <= 1'b0;
         use_imm_q <= 1'b0;
         cnt_q     <= '0;
         op_q      <= OP_NONE;
         imm_q     <= '0;
         acc_q     <= '0;
         ptr_q     <= '0;
         home_q    <= '0;
         wr_reg    <= '0;
         wr_en     <= '0;
         wr_idx    <= '0;
         wr_data   <= '0;
         for (int i = 0; i < N_ELEM; i++) begin
            s1_q[i] <= '0;
            s2_q[i] <= '0;
         end
      end else begin
         wr_en <= '0;
         if (accept) begin
            busy_q    <= 1'b1;
            red_q     <= d_reduce;
            split_q   <= SPLIT_EN && d_split;
            use_imm_q <= d_use_imm;
            op_q      <= alu_op_e'(iss_op);
            imm_q     <= d_imm_sel;
            cnt_q     <= '0;
            home_q    <= d_home;
            ptr_q     <= d_home + 1'b1;
            acc_q     <= rd_data_a[int'(d_home)*ELEM_W +: ELEM_W];
            wr_reg    <= d_dst;
            for (int i = 0; i < N_ELEM; i++) begin
               s1_q[i] <= rd_data_a[i*ELEM_W +: ELEM_W];
               s2_q[i] <= rd_data_b[i*ELEM_W +: ELEM_W];
            end
         end else if (busy_q) begin
            cnt_q <= cnt_q + 1'b1;
            if (!red_q) begin
               for (int u = 0; u < N_UNITS; u++) begin
                  wr_en[u]                     <= op_ok;
                  wr_idx[u*IDX_W +: IDX_W]     <= elem_idx[u];
                  wr_data[u*ELEM_W +: ELEM_W]  <= unit_y[u];
               end
               if (cnt_q == LAST_PAIR) busy_q <= 1'b0;
            end else begin
               acc_q <= unit_y[0];
               ptr_q <= ptr_q + 1'b1;
               if (cnt_q == LAST_FOLD) begin
                  busy_q              <= 1'b0;
                  wr_en[0]            <= op_ok;
                  wr_idx[0 +: IDX_W]  <= home_q;
                  wr_data[0 +: ELEM_W] <= unit_y[0];
               end
            end
         end
      end
   end

   // ---------------------------------------------------------------
   AST_BUSY_AFTER_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && iss_ready) |=> !iss_ready); // R8

   AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_q && !$past(busy_q)) |-> (wr_en == '0)); // R1

   AST_DEST_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      ((wr_en != '0) && ($past(wr_en) != '0)) |-> $stable(wr_reg)); // R2

   AST_NONE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en != '0) |-> (op_q != OP_NONE)); // R10

   AST_FOLD_HOME: assert property (@(posedge clk) disable iff (!rst_n)
      (red_q && (wr_en != '0)) |-> ((wr_en == N_UNITS'(1)) && (wr_idx[0 +: IDX_W] == home_q))); // R9

   generate
      if (N_UNITS > 1) begin : g_pair_chk
         AST_PAIR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en == '1) |-> (wr_idx[IDX_W +: IDX_W] == wr_idx[0 +: IDX_W] + 1'b1)); // R8
         AST_PAIR_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
            ((wr_en == '1) && (wr_idx[0 +: IDX_W] != '0)) |->
            (($past(wr_en) == '1) && ($past(wr_idx[0 +: IDX_W]) + IDX_W'(N_UNITS) == wr_idx[0 +: IDX_W]))); // R8
      end
   endgenerate
endmodule

// File: tb/sim_stsimd_int_alu.sv
module sim_stsimd_int_alu;
   localparam int CLK_PER = 10;
   localparam int EW = 64;
   localparam int NE = 8;
   localparam int NU = 2;
   localparam int IW = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PER/2) clk = ~clk;

   logic            iss_valid = 1'b0;
   logic            iss_ready;
   logic [2:0]      iss_op = '0;
   logic [23:0]     iss_ctrl = '0;
   logic [1:0]      rd_reg_a, rd_reg_b, wr_reg;
   logic [NE*EW-1:0] rd_data_a, rd_data_b;
   logic [NU-1:0]   wr_en;
   logic [NU*IW-1:0] wr_idx;
   logic [NU*EW-1:0] wr_data;

   logic [EW-1:0] lr [4][NE];

   for (genvar e = 0; e < NE; e++) begin : g_rd
      assign rd_data_a[e*EW +: EW] = lr[rd_reg_a][e];
      assign rd_data_b[e*EW +: EW] = lr[rd_reg_b][e];
   end

   stsimd_int_alu u0 (
      .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready),
      .iss_op(iss_op), .iss_ctrl(iss_ctrl), .rd_reg_a(rd_reg_a), .rd_reg_b(rd_reg_b),
      .rd_data_a(rd_data_a), .rd_data_b(rd_data_b), .wr_reg(wr_reg),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
   );

   int tests = 0;
   int fails = 0;
   int cyc = 0;
   int n_wr = 0;
   int first_wr = 0;
   int last_wr = 0;
   logic [63:0] seed = 64'h1234_5678_9abc_def1;

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (rst_n) begin
         for (int u = 0; u < NU; u++) begin
            if (wr_en[u]) begin
               lr[wr_reg][wr_idx[u*IW +: IW]] = wr_data[u*EW +: EW];
               if (n_wr == 0) first_wr = cyc;
               last_wr = cyc;
               n_wr++;
            end
         end
      end
   end

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] ref_lane(input int op, input logic [63:0] a_in,
                                            input logic [63:0] b_in, input int w);
      logic [63:0] m, a, b, r;
      logic lt;
      m = (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
      a = a_in & m;
      b = b_in & m;
      r = '0;
      case (op)
         0: r = a + b;
         1: r = a - b;
         2: begin
            if (w == 64) lt = $signed(a) < $signed(b);
            else         lt = $signed(a[31:0]) < $signed(b[31:0]);
            r = lt ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0;
         end
         3: r = a << (b & 64'(w - 1));
         4: r = a & b;
         5: r = a | b;
         6: r = a ^ b;
         default: r = '0;
      endcase
      return r & m;
   endfunction

   function automatic logic [63:0] ref_elem(input int op, input logic [63:0] a,
                                            input logic [63:0] b, input logic split);
      logic [63:0] lo, hi;
      if (!split) return ref_lane(op, a, b, 64);
      lo = ref_lane(op, {32'h0, a[31:0]}, {32'h0, b[31:0]}, 32);
      hi = ref_lane(op, {32'h0, a[63:32]}, {32'h0, b[63:32]}, 32);
      return {hi[31:0], lo[31:0]};
   endfunction

   function automatic logic [63:0] next_rand();
      seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
      return seed ^ (seed >> 29);
   endfunction

   task automatic fill_regs(input int k);
      logic [63:0] corner [5];
      corner[0] = 64'h8000_0000_0000_0000;
      corner[1] = 64'h7FFF_FFFF_FFFF_FFFF;
      corner[2] = 64'hFFFF_FFFF_FFFF_FFFF;
      corner[3] = 64'h7FFF_FFFF_8000_0000;
      corner[4] = 64'h0000_0000_FFFF_FFFF;
      for (int r = 0; r < 4; r++)
         for (int e = 0; e < NE; e++)
            lr[r][e] = (((e + r + k) % 3) == 0) ? corner[(e + r + k) % 5] : next_rand();
   endtask

   task automatic run(input int op, input logic split, input logic use_imm, input logic red,
                      input logic [14:0] imm, input int dst, input int sa, input int sb);
      logic [63:0] s1 [NE];
      logic [63:0] s2 [NE];
      logic [63:0] exp [NE];
      logic [63:0] immx, acc;
      int h, t0, t_rdy;
      h = int'(imm[14:12]);
      immx = split ? {{17{imm[14]}}, imm, {17{imm[14]}}, imm} : {{49{imm[14]}}, imm};
      for (int e = 0; e < NE; e++) begin
         s1[e] = lr[sa][e];
         s2[e] = lr[sb][e];
         exp[e] = lr[dst][e];
      end
      if (op != 7) begin
         if (red) begin
            acc = s1[h];
            for (int j = 1; j < NE; j++) acc = ref_elem(op, acc, s1[(h + j) % NE], split);
            exp[h] = acc;
         end else begin
            for (int e = 0; e < NE; e++)
               exp[e] = ref_elem(op, s1[e], use_imm ? immx : s2[e], split);
         end
      end
      @(negedge clk);
      iss_op    = 3'(op);
      iss_ctrl  = {2'(dst), 2'(sa), 2'(sb), split, use_imm, red, imm};
      iss_valid = 1'b1;
      #1;
      chk(rd_reg_a == 2'(sa) && rd_reg_b == 2'(sb), "R2 source select",
          {60'h0, rd_reg_a, rd_reg_b}, {60'h0, 2'(sa), 2'(sb)});
      n_wr = 0;
      @(posedge clk);
      #1;
      t0 = cyc;
      iss_valid = 1'b0;
      @(negedge clk);
      chk(!iss_ready, "R8 busy after issue", 64'(iss_ready), 64'h0);
      while (!iss_ready) @(negedge clk);
      t_rdy = cyc;
      @(posedge clk);
      #1;
      for (int e = 0; e < NE; e++) begin
         case (op)
            2: chk(lr[dst][e] == exp[e], "R4 compare", lr[dst][e], exp[e]);
            3: chk(lr[dst][e] == exp[e], "R5 shift", lr[dst][e], exp[e]);
            7: chk(lr[dst][e] == exp[e], "R10 reserved code unchanged", lr[dst][e], exp[e]);
            default: chk(lr[dst][e] == exp[e], "R3 arithmetic/logic", lr[dst][e], exp[e]);
         endcase
         if (split) chk(lr[dst][e] == exp[e], "R7 split lanes", lr[dst][e], exp[e]);
         if (use_imm && !red) chk(lr[dst][e] == exp[e], "R6 immediate operand", lr[dst][e], exp[e]);
         if (red) chk(lr[dst][e] == exp[e], "R9 reduction result", lr[dst][e], exp[e]);
      end
      if (op == 7) begin
         chk(n_wr == 0, "R10 no write", 64'(n_wr), 64'h0);
      end else if (red) begin
         chk(n_wr == 1, "R9 single write", 64'(n_wr), 64'h1);
         chk(first_wr == t0 + NE - 1, "R9 write cycle", 64'(first_wr - t0), 64'(NE - 1));
         chk(t_rdy == t0 + NE - 1, "R9 ready cycle", 64'(t_rdy - t0), 64'(NE - 1));
      end else begin
         chk(n_wr == NE, "R8 write count", 64'(n_wr), 64'(NE));
         chk(first_wr == t0 + 1, "R8 first pair cycle", 64'(first_wr - t0), 64'h1);
         chk(last_wr == t0 + NE / NU, "R8 last pair cycle", 64'(last_wr - t0), 64'(NE / NU));
         chk(t_rdy == t0 + NE / NU, "R8 ready cycle", 64'(t_rdy - t0), 64'(NE / NU));
      end
   endtask

   initial begin : p_watchdog
      #(CLK_PER * 150000);
      fails++;
      tests++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin : p_main
      int k;
      logic [14:0] imm;
      fill_regs(0);
      repeat (3) @(posedge clk);
      #1;
      chk(iss_ready == 1'b1, "R1 ready in reset", 64'(iss_ready), 64'h1);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(iss_ready == 1'b1, "R1 ready after reset", 64'(iss_ready), 64'h1);
      chk(wr_en == '0, "R1 no write after reset", 64'(wr_en), 64'h0);
      k = 0;
      for (int op = 0; op < 8; op++)
         for (int sp = 0; sp < 2; sp++)
            for (int ui = 0; ui < 2; ui++)
               for (int rd = 0; rd < 2; rd++)
                  for (int rep = 0; rep < 2; rep++) begin
                     k++;
                     fill_regs(k);
                     imm = {3'((op + 3 * rep + 2 * sp + ui) % 8),
                            (rep == 0) ? 12'hA5C : 12'h027};
                     run(op, sp[0], ui[0], rd[0], imm,
                         (op + rep) % 4, (op + 1) % 4, (op + 2 + sp) % 4);
                  end
      // idle: no stray writes
      n_wr = 0;
      repeat (5) @(negedge clk);
      chk(n_wr == 0, "R1 idle no write", 64'(n_wr), 64'h0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule